// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block RAM

This block is a 4608-bit memory, held as 512 words of nine bits, with one write port and one read port on separate clocks. Each port picks its own data width at run time through a 3-bit code. Data can therefore go in at one width and come out at another, which makes the block a bus-width converter as well as a store. Either code may change between accesses.

Storage sits in four banks of 128 nine-bit rows, so a 36-bit access touches one row in every bank in the same cycle. The narrow modes (x1, x2, x4) address only the low eight bits of each nine-bit word. Multi-word modes (x18, x36) are little-endian. The read data is registered on the read clock and can pass through one extra output register. Each clock has its own polarity select.

Top module: `mw_dpram`

## Requirements
- R1: Width codes are 000=x1, 001=x2, 010=x4, 011=x9, 100=x18 and 101=x36. Read data sits in the low bits of `rd_data`, and every bit above the selected width reads as zero.
- R2: At x36 an access covers words 4*addr[6:0]+k, and at x18 it covers words 2*addr[7:0]+k. Word k occupies data bits [9k+8:9k], so the lowest-addressed word sits in bits [8:0].
- R3: At x4 the word is addr[9:1] and the lane is bits [4s+3:4s] with s=addr[0]. At x2 the word is addr[10:2] and the lane is bits [2s+1:2s] with s=addr[1:0]. At x1 the word is addr[11:3] and the bit is s=addr[2:0].
- R4: A narrow write changes only its own lane. Bit 8 and the other lanes of that word keep their values.
- R5: Data written at any width reads back at any other width according to the mappings in R2 and R3.
- R6: Address bits above those the current width needs are ignored.
- R7: A write happens only on an active write-clock edge with `wr_en` high. With `wr_en` low the memory is unchanged.
- R8: With `rd_en` high, the read data appears after one active read-clock edge. With `rd_en` low, `rd_data` holds its value.
- R9: A reserved code (11x) on `wr_width` makes a write do nothing. On `rd_width` it makes `rd_data` hold.
- R10: With `rd_pipe` high, read data appears one active read-clock edge later than with it low.
- R11: With `wr_clk_inv` or `rd_clk_inv` high, that port acts on the falling edge of its clock instead of the rising edge.
- R12: While `rst_n` is low, the read registers clear and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| wr_clk | input | 1 | Write clock |
| wr_clk_inv | input | 1 | 1 = write on the falling edge |
| wr_en | input | 1 | Write enable |
| wr_width | input | 3 | Write width code |
| wr_addr | input | 12 | Write address |
| wr_data | input | 36 | Write data, low bits used |
| rd_clk | input | 1 | Read clock |
| rd_clk_inv | input | 1 | 1 = read on the falling edge |
| rd_en | input | 1 | Read enable |
| rd_width | input | 3 | Read width code |
| rd_addr | input | 12 | Read address |
| rd_pipe | input | 1 | 1 = add one output register |
| rd_data | output | 36 | Read data |

## Verification
A wrong bank select or a wrong lane shift corrupts memory without any sign at the time of the write. It shows up only when that word is read back, and possibly at another width. For that reason every width is swept across its whole address range after fills done at other widths. A wrong read-register update shows at the ports within one read edge, as a changed value while the enable is low or as nonzero bits above the selected width. A pipeline fault shows as data arriving one edge early or one edge late.

// File: rtl/mw_dpram_pkg.sv
package mw_dpram_pkg;

    localparam int WORD_W = 9;
    localparam int DEPTH  = 512;
    localparam int BANKS  = 4;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 36;
    localparam int ROWS   = DEPTH / BANKS;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int WIDX_W = $clog2(DEPTH);
    localparam int BSEL_W = $clog2(BANKS);
    localparam int SEL_W  = 3;

    localparam logic [2:0] CODE_X1  = 3'd0;
    localparam logic [2:0] CODE_X2  = 3'd1;
    localparam logic [2:0] CODE_X4  = 3'd2;
    localparam logic [2:0] CODE_X9  = 3'd3;
    localparam logic [2:0] CODE_X18 = 3'd4;
    localparam logic [2:0] CODE_X36 = 3'd5;

    typedef struct packed {
        logic              valid;
        logic              narrow;
        logic [WIDX_W-1:0] widx;
        logic [SEL_W-1:0]  sel;
        logic [3:0]        lane;
    } loc_t;

    typedef struct packed {
        logic [DATA_W-1:0] stage2;
        logic [DATA_W-1:0] stage1;
    } rd_regs_t;

    // Maps a width code and an address to a 9-bit word index and a lane.
    function automatic loc_t decode_loc(input logic [2:0] code, input logic [ADDR_W-1:0] a);
        loc_t l;
        l = '0;
        l.valid = 1'b1;
        case (code)
            CODE_X1: begin
                l.widx = WIDX_W'(a >> 3);
                l.sel = a[2:0];
                l.lane = 4'd1;
                l.narrow = 1'b1;
            end
            CODE_X2: begin
                l.widx = WIDX_W'(a >> 2);
                l.sel = {1'b0, a[1:0]};
                l.lane = 4'd2;
                l.narrow = 1'b1;
            end
            CODE_X4: begin
                l.widx = WIDX_W'(a >> 1);
                l.sel = {2'b00, a[0]};
                l.lane = 4'd4;
                l.narrow = 1'b1;
            end
            CODE_X9:  l.widx = WIDX_W'(a);
            CODE_X18: l.widx = WIDX_W'({a, 1'b0});
            CODE_X36: l.widx = WIDX_W'({a, 2'b00});
            default:  l.valid = 1'b0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/mw_dpram_wr_decode.sv
module mw_dpram_wr_decode
    import mw_dpram_pkg::*;
(
    input  logic                          wr_en,
    input  logic [2:0]                    wr_width,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [ROW_W-1:0]              row,
    output logic [BANKS-1:0]              bank_we,
    output logic [BANKS-1:0][WORD_W-1:0]  bank_mask,
    output logic [BANKS-1:0][WORD_W-1:0]  bank_wdata
);

    loc_t              loc;
    logic [BSEL_W-1:0] bidx;
    logic [WORD_W-1:0] ones;
    int                sh;

    always_comb begin
        loc        = decode_loc(wr_width, wr_addr);
        row        = loc.widx[WIDX_W-1:BSEL_W];
        bank_we    = '0;
        bank_mask  = '0;
        bank_wdata = '0;
        ones       = WORD_W'((1 << loc.lane) - 1);
        sh         = int'(loc.lane) * int'(loc.sel);
        bidx       = '0;
        for (int b = 0; b < BANKS; b++) begin
            bidx = BSEL_W'(b);
            case (wr_width)
                CODE_X36: begin
                    bank_we[b]    = 1'b1;
                    bank_mask[b]  = '1;
                    bank_wdata[b] = wr_data[b*WORD_W +: WORD_W];
                end
                CODE_X18: begin
                    if (bidx[BSEL_W-1] == loc.widx[1]) begin
                        bank_we[b]    = 1'b1;
                        bank_mask[b]  = '1;
                        bank_wdata[b] = wr_data[int'(bidx[0])*WORD_W +: WORD_W];
                    end
                end
                CODE_X9: begin
                    if (bidx == loc.widx[BSEL_W-1:0]) begin
                        bank_we[b]    = 1'b1;
                        bank_mask[b]  = '1;
                        bank_wdata[b] = wr_data[WORD_W-1:0];
                    end
                end
                default: begin
                    if (loc.narrow && (bidx == loc.widx[BSEL_W-1:0])) begin
                        bank_we[b]    = 1'b1;
                        bank_mask[b]  = ones << sh;
                        bank_wdata[b] = (wr_data[WORD_W-1:0] & ones) << sh;
                    end
                end
            endcase
        end
        if (!(wr_en && loc.valid)) begin
            bank_we = '0;
        end
    end

endmodule

// File: rtl/mw_dpram_bank.sv
module mw_dpram_bank #(
    parameter int ROWS   = 128,
    parameter int WORD_W = 9,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row_w,
    input  logic [WORD_W-1:0] mask,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ROW_W-1:0]  row_r,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [ROWS];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[row_w] <= (mem[row_w] & ~mask) | (wdata & mask);
        end
    end

    assign rdata = mem[row_r];

endmodule

// File: rtl/mw_dpram_rd_select.sv
module mw_dpram_rd_select
    import mw_dpram_pkg::*;
(
    input  logic [2:0]                    rd_width,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [BANKS-1:0][WORD_W-1:0]  bank_rdata,
    output logic                          valid,
    output logic [ROW_W-1:0]              row,
    output logic [DATA_W-1:0]             data
);

    loc_t              loc;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] ones;
    int                sh;

    always_comb begin
        loc   = decode_loc(rd_width, rd_addr);
        valid = loc.valid;
        row   = loc.widx[WIDX_W-1:BSEL_W];
        word  = bank_rdata[loc.widx[BSEL_W-1:0]];
        ones  = WORD_W'((1 << loc.lane) - 1);
        sh    = int'(loc.lane) * int'(loc.sel);
        data  = '0;
        case (rd_width)
            CODE_X36: data = bank_rdata;
            CODE_X18: begin
                data[WORD_W-1:0]        = bank_rdata[{loc.widx[1], 1'b0}];
                data[2*WORD_W-1:WORD_W] = bank_rdata[{loc.widx[1], 1'b1}];
            end
            CODE_X9: data[WORD_W-1:0] = word;
            default: begin
                if (loc.narrow) begin
                    data[WORD_W-1:0] = (word >> sh) & ones;
                end
            end
        endcase
    end

endmodule

// File: rtl/mw_dpram.sv
module mw_dpram
    import mw_dpram_pkg::*;
(
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_clk_inv,
    input  logic              wr_en,
    input  logic [2:0]        wr_width,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_clk_inv,
    input  logic              rd_en,
    input  logic [2:0]        rd_width,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_pipe,
    output logic [DATA_W-1:0] rd_data
);

    logic                         wclk;
    logic                         rclk;
    logic [ROW_W-1:0]             wrow;
    logic [ROW_W-1:0]             rrow;
    logic [BANKS-1:0]             bank_we;
    logic [BANKS-1:0][WORD_W-1:0] bank_mask;
    logic [BANKS-1:0][WORD_W-1:0] bank_wdata;
    logic [BANKS-1:0][WORD_W-1:0] bank_rdata;
    logic                         rd_valid;
    logic [DATA_W-1:0]            rd_sel_data;
    rd_regs_t                     rd_d;
    rd_regs_t                     rd_q;

    // Per-port edge polarity.
    assign wclk = wr_clk ^ wr_clk_inv;
    assign rclk = rd_clk ^ rd_clk_inv;

    mw_dpram_wr_decode u_wr_decode (
        .wr_en      (wr_en),
        .wr_width   (wr_width),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .row        (wrow),
        .bank_we    (bank_we),
        .bank_mask  (bank_mask),
        .bank_wdata (bank_wdata)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        mw_dpram_bank #(
            .ROWS   (ROWS),
            .WORD_W (WORD_W)
        ) u_bank (
            .wclk  (wclk),
            .we    (bank_we[g]),
            .row_w (wrow),
            .mask  (bank_mask[g]),
            .wdata (bank_wdata[g]),
            .row_r (rrow),
            .rdata (bank_rdata[g])
        );
    end

    mw_dpram_rd_select u_rd_select (
        .rd_width   (rd_width),
        .rd_addr    (rd_addr),
        .bank_rdata (bank_rdata),
        .valid      (rd_valid),
        .row        (rrow),
        .data       (rd_sel_data)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en && rd_valid) begin
            rd_d.stage1 = rd_sel_data;
        end
        rd_d.stage2 = rd_q.stage1;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_pipe ? rd_q.stage2 : rd_q.stage1;

endmodule

// File: rtl/mw_dpram_chk.sv
module mw_dpram_chk
    import mw_dpram_pkg::*;
(
    input logic              rclk,
    input logic              wclk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_width,
    input logic [BANKS-1:0]  bank_we,
    input logic              rd_en,
    input logic [2:0]        rd_width,
    input logic              rd_pipe,
    input logic [DATA_W-1:0] stage1,
    input logic [DATA_W-1:0] rd_data
);

    // R7 and R9: no bank is written while disabled or with a reserved code.
    assert_no_write_R9: assert property (@(posedge wclk) disable iff (!rst_n)
        (!wr_en || (wr_width[2:1] == 2'b11)) |-> (bank_we == '0));

    // R2: a 36-bit write touches every bank.
    assert_all_banks_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && (wr_width == CODE_X36)) |-> (bank_we == '1));

    // R3: x1, x2, x4 and x9 writes touch exactly one bank.
    assert_one_bank_R3: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && (wr_width <= CODE_X9)) |-> ($countones(bank_we) == 1));

    // R8: the output holds while reads are disabled or reserved.
    assert_hold_R8: assert property (@(posedge rclk) disable iff (!rst_n)
        ((!rd_en || (rd_width[2:1] == 2'b11)) && !rd_pipe) |=> (rd_pipe || $stable(rd_data)));

    // R1: bits above the lane width read as zero.
    assert_x4_upper_zero_R1: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && (rd_width == CODE_X4) && !rd_pipe) |=> (rd_pipe || (rd_data[DATA_W-1:4] == '0)));

    assert_x9_upper_zero_R1: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && (rd_width == CODE_X9) && !rd_pipe) |=> (rd_pipe || (rd_data[DATA_W-1:WORD_W] == '0)));

    // R10: with the pipe on, the output lags the first stage by one edge.
    assert_pipe_lag_R10: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_pipe |=> (!rd_pipe || (rd_data == $past(stage1))));

endmodule

bind mw_dpram mw_dpram_chk u_chk (
    .rclk     (rclk),
    .wclk     (wclk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_width (wr_width),
    .bank_we  (bank_we),
    .rd_en    (rd_en),
    .rd_width (rd_width),
    .rd_pipe  (rd_pipe),
    .stage1   (rd_q.stage1),
    .rd_data  (rd_data)
);

// File: tb/tb_mw_dpram.sv
`timescale 1ns/1ps
module tb_mw_dpram;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_clk_inv, wr_en, rd_clk_inv, rd_en, rd_pipe;
    logic [2:0]  wr_width, rd_width;
    logic [11:0] wr_addr, rd_addr;
    logic [35:0] wr_data, rd_data;

    int checks = 0;
    int fails  = 0;
    bit refmem [0:4607];

    always #4 clk = ~clk;

    mw_dpram dut (
        .rst_n      (rst_n),
        .wr_clk     (clk),
        .wr_clk_inv (wr_clk_inv),
        .wr_en      (wr_en),
        .wr_width   (wr_width),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_clk     (clk),
        .rd_clk_inv (rd_clk_inv),
        .rd_en      (rd_en),
        .rd_width   (rd_width),
        .rd_addr    (rd_addr),
        .rd_pipe    (rd_pipe),
        .rd_data    (rd_data)
    );

    function automatic int lanes(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 9;
            3'd4: return 18;
            3'd5: return 36;
            default: return 0;
        endcase
    endfunction

    // Bit position in refmem of data bit i of an access at (code, addr).
    function automatic int bitpos(input logic [2:0] c, input int a, input int i);
        int n, q, per, e;
        n = lanes(c);
        if (n >= 9) begin
            q = n / 9;
            return ((a % (512 / q)) * q + i / 9) * 9 + i % 9;
        end
        per = 8 / n;
        e = a % (512 * per);
        return (e / per) * 9 + (e % per) * n + i;
    endfunction

    function automatic logic [35:0] pat(input int a, input int salt);
        logic [31:0] h;
        h = 32'(a) * 32'h9E3779B1 + 32'(salt) * 32'h7F4A7C15;
        return {h[3:0] ^ 4'(a), h};
    endfunction

    task automatic model_write(input logic [2:0] c, input int a, input logic [35:0] d);
        for (int i = 0; i < lanes(c); i++) refmem[bitpos(c, a, i)] = d[i];
    endtask

    function automatic logic [35:0] model_read(input logic [2:0] c, input int a);
        logic [35:0] r;
        r = '0;
        for (int i = 0; i < lanes(c); i++) r[i] = refmem[bitpos(c, a, i)];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] c, input int a, input logic [35:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_width = c; wr_addr = 12'(a); wr_data = d;
        model_write(c, a, d);
    endtask

    task automatic wr_idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] c, input int a, input string req);
        logic [35:0] e;
        @(negedge clk);
        rd_en = 1'b1; rd_width = c; rd_addr = 12'(a);
        @(negedge clk);
        rd_en = 1'b0;
        e = model_read(c, a);
        check(rd_data === e, req, rd_data, e);
    endtask

    task automatic sweep(input logic [2:0] c, input string req);
        for (int a = 0; a < 4608 / lanes(c) / (lanes(c) < 9 ? 1 : 1) && a < (lanes(c) < 9 ? 512 * (8 / lanes(c)) : 512 / (lanes(c) / 9)); a++)
            rd_chk(c, a, req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [35:0] held, prev, nv;
        rst_n = 1'b0; wr_clk_inv = 1'b0; rd_clk_inv = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        rd_pipe = 1'b0; wr_width = 3'd5; rd_width = 3'd5; wr_addr = '0; rd_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check(rd_data === 36'd0, "R12", rd_data, 36'd0);
        rst_n = 1'b1;

        // Fill at x36, then read at every width (R2, R3, R5, R1).
        for (int a = 0; a < 128; a++) wr(3'd5, a, pat(a, 1));
        wr_idle();
        sweep(3'd5, "R2");
        sweep(3'd4, "R2");
        sweep(3'd3, "R5");
        sweep(3'd2, "R3");
        sweep(3'd1, "R3");
        sweep(3'd0, "R1");

        // Narrow writes keep the ninth bit and other lanes (R4).
        for (int a = 0; a < 1024; a++) wr(3'd2, a, pat(a, 2));
        wr_idle();
        sweep(3'd3, "R4");
        for (int a = 0; a < 512; a++) wr(3'd1, a, pat(a, 3));
        wr_idle();
        sweep(3'd5, "R4");
        for (int a = 0; a < 1024; a++) wr(3'd0, a * 3, pat(a, 4));
        wr_idle();
        sweep(3'd4, "R5");
        for (int a = 0; a < 256; a += 3) wr(3'd4, a, pat(a, 5));
        wr_idle();
        for (int a = 0; a < 1024; a += 5) rd_chk(3'd2, a, "R5");

        // Unused upper address bits (R6).
        wr(3'd3, 12'hE05, 36'h1A5);
        wr(3'd5, 12'hF81, pat(9, 6));
        wr_idle();
        rd_chk(3'd3, 5, "R6");
        rd_chk(3'd3, 12'h205, "R6");
        rd_chk(3'd5, 1, "R6");
        rd_chk(3'd5, 12'hA81, "R6");

        // Write with enable low (R7).
        @(negedge clk);
        wr_en = 1'b0; wr_width = 3'd3; wr_addr = 12'd7; wr_data = 36'h0AA;
        @(negedge clk);
        rd_chk(3'd3, 7, "R7");

        // Hold with read enable low (R8).
        rd_chk(3'd5, 33, "R8");
        held = rd_data;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rd_addr = 12'(k * 17 + 2);
            @(negedge clk);
            check(rd_data === held, "R8", rd_data, held);
        end

        // Reserved codes (R9).
        wr(3'd6, 0, '1);
        wr(3'd7, 1, '1);
        wr_idle();
        rd_chk(3'd5, 0, "R9");
        rd_chk(3'd5, 1, "R9");
        held = rd_data;
        @(negedge clk);
        rd_en = 1'b1; rd_width = 3'd7; rd_addr = 12'd50;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data === held, "R9", rd_data, held);

        // Output pipeline (R10).
        @(negedge clk);
        rd_pipe = 1'b1;
        @(negedge clk);
        prev = rd_data;
        rd_en = 1'b1; rd_width = 3'd5; rd_addr = 12'd77;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data === prev, "R10", rd_data, prev);
        @(negedge clk);
        nv = model_read(3'd5, 77);
        check(rd_data === nv, "R10", rd_data, nv);
        rd_pipe = 1'b0;

        // Clock polarity (R11): pulse the enable only around a falling edge.
        @(negedge clk);
        wr_clk_inv = 1'b1;
        @(posedge clk); #2;
        wr_en = 1'b1; wr_width = 3'd3; wr_addr = 12'd300; wr_data = 36'h155;
        model_write(3'd3, 300, 36'h155);
        @(negedge clk); #2;
        wr_en = 1'b0;
        @(posedge clk); #2;
        wr_clk_inv = 1'b0;
        rd_chk(3'd3, 300, "R11");
        @(posedge clk); #2;
        wr_en = 1'b1; wr_width = 3'd3; wr_addr = 12'd300; wr_data = 36'h0F0;
        @(negedge clk); #2;
        wr_en = 1'b0;
        rd_chk(3'd3, 300, "R11");
        @(negedge clk);
        rd_clk_inv = 1'b1;
        @(posedge clk); #2;
        rd_en = 1'b1; rd_width = 3'd3; rd_addr = 12'd301;
        @(negedge clk); #2;
        rd_en = 1'b0;
        nv = model_read(3'd3, 301);
        check(rd_data === nv, "R11", rd_data, nv);
        @(posedge clk); #2;
        rd_clk_inv = 1'b0;

        finish_run();
    end

endmodule